// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the word a host sees when it reads a flash bank while an internal program or erase algorithm is running there. It does not run the algorithm. It takes the algorithm's state as flags: the kind of operation, busy, suspended, time limit exceeded, erase begun and buffer abort. It also takes the word being programmed and the set of sectors marked for erase. From these it builds polling status bits. When no operation is visible to the addressed sector, it returns the array word unchanged.

Two of the status bits change with every read and do not hold a level. A host tells "still working" from "finished" by reading twice and comparing. Both toggle bits advance once per read request, not once per clock. A separate ready output behaves like an open-drain ready/busy line: it is low while an algorithm or a hardware reset is in progress.

Reads are requested with a one-cycle strobe that carries a sector index. The answer appears registered on the next cycle, together with a one-cycle valid pulse.

Top module: `eo_status_gen`

## Requirements
- R1: While `rst_n` is low, `rd_valid` and `ready` are both 0.
- R2: A read request is answered on the cycle after the strobe with `rd_data` and a `rd_valid` pulse lasting exactly one cycle. No pulse appears without a request.
- R3: With `busy` and `suspended` both 0, or with `op_kind` set to none (0), a read returns `array_data` unchanged. Once a program completes, this is the true data.
- R4: During a busy program (`op_kind`=1), status bit 7 is the inverse of bit 7 of `prog_data`, bit 2 is 1, and bit 3 is 0. Bits 4, 0 and every bit above 7 are 0 in any status word.
- R5: Bit 6 is 0 on the first status read after reset and flips on every status read while a program or erase is busy. Array-data reads and erase-suspend reads do not advance it.
- R6: During a busy erase (`op_kind`=2), bit 2 flips on each read of a sector whose `erase_sel` bit is set, and starts at 0. It reads 1 for other sectors, and those reads do not advance it.
- R7: During a busy erase, bit 7 is 0 and bit 3 equals `erase_begun`.
- R8: During a busy program or erase, bit 5 equals `time_exceeded`. In an erase-suspend status word, bit 5 is 0.
- R9: Bit 1 equals `buf_abort` during a busy program and is 0 in every erase status word.
- R10: With `suspended`=1 and `op_kind`=2, a read of a selected sector returns status with bit 7 = 1, bit 6 held at its last value, bits 5, 3 and 1 at 0, and bit 2 advancing as in R6. A read of an unselected sector returns `array_data`. Suspension takes priority over `busy`.
- R11: `ready` is 0 on the cycle after a cycle in which `busy` or `hw_reset` is 1. It is 1 on the cycle after a cycle in which both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind | input | 2 | 0 none, 1 program, 2 erase |
| busy | input | 1 | Algorithm running |
| suspended | input | 1 | Operation suspended |
| time_exceeded | input | 1 | Internal time limit exceeded |
| erase_begun | input | 1 | Erase command window closed, erase running |
| buf_abort | input | 1 | Buffered program aborted |
| hw_reset | input | 1 | Hardware reset in progress |
| prog_data | input | DATA_W | Word being programmed |
| erase_sel | input | NSECT | One bit per sector marked for erase |
| rd_req | input | 1 | Read strobe, one cycle per read |
| rd_sector | input | SECT_W | Sector index of the read |
| array_data | input | DATA_W | Array word at the read address |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | Read result valid pulse |
| ready | output | 1 | High when idle, low while busy or in hardware reset |

## Verification
The bench builds the block with its defaults: a 16-bit word and 16 sectors. This puts the status bits in the low byte and leaves eight upper bits that must stay zero in every status word. The erase selection covers sectors 2, 5 and 15, so the topmost sector index and the unselected sectors between them are all reached. The sequence runs a program, then an erase, a suspend and a resume. Toggle history therefore carries across phases, and the hold rules of R5 and R10 can be seen across them.

// File: rtl/eosg_pkg.sv
package eosg_pkg;

  typedef enum logic [1:0] {
    OPK_NONE  = 2'd0,
    OPK_PROG  = 2'd1,
    OPK_ERASE = 2'd2,
    OPK_RSVD  = 2'd3
  } opk_e;

  typedef enum logic [1:0] {
    MD_ARRAY = 2'd0,
    MD_PROG  = 2'd1,
    MD_ERASE = 2'd2,
    MD_ESUSP = 2'd3
  } rd_mode_e;

  localparam int STAT_W = 8;
  localparam int B_POLL = 7;
  localparam int B_TOGA = 6;
  localparam int B_TERR = 5;
  localparam int B_ERUN = 3;
  localparam int B_TOGB = 2;
  localparam int B_ABRT = 1;

endpackage

// File: rtl/eosg_mode_dec.sv
module eosg_mode_dec
  import eosg_pkg::*;
#(
  parameter int NSECT  = 16,
  parameter int SECT_W = 4
) (
  input  logic [1:0]        op_kind,
  input  logic              busy,
  input  logic              suspended,
  input  logic [NSECT-1:0]  erase_sel,
  input  logic [SECT_W-1:0] rd_sector,
  output rd_mode_e          mode,
  output logic              sect_hit
);

  logic [NSECT-1:0] sect_dec;
  opk_e             kind;

  genvar g;
  generate
    for (g = 0; g < NSECT; g++) begin : g_dec
      assign sect_dec[g] = erase_sel[g] && (rd_sector == SECT_W'(g));
    end
  endgenerate

  assign sect_hit = |sect_dec;

  always_comb begin
    kind = opk_e'(op_kind);
    mode = MD_ARRAY;
    if (suspended && kind == OPK_ERASE) begin
      mode = sect_hit ? MD_ESUSP : MD_ARRAY;
    end else if (busy && !suspended) begin
      case (kind)
        OPK_PROG:  mode = MD_PROG;
        OPK_ERASE: mode = MD_ERASE;
        default:   mode = MD_ARRAY;
      endcase
    end
  end

endmodule

// File: rtl/eosg_toggle.sv
module eosg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic q
);

  logic q_nx;

  always_comb begin
    q_nx = ~q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (adv) begin
      q <= q_nx;
    end
  end

endmodule

// File: rtl/eosg_word_build.sv
module eosg_word_build
  import eosg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  rd_mode_e          mode,
  input  logic              sect_hit,
  input  logic              tog_a,
  input  logic              tog_b,
  input  logic              time_exceeded,
  input  logic              erase_begun,
  input  logic              buf_abort,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] word
);

  logic [STAT_W-1:0] stat;

  always_comb begin
    stat = '0;
    case (mode)
      MD_PROG: begin
        stat[B_POLL] = ~prog_data[B_POLL];
        stat[B_TOGA] = tog_a;
        stat[B_TERR] = time_exceeded;
        stat[B_TOGB] = 1'b1;
        stat[B_ABRT] = buf_abort;
      end
      MD_ERASE: begin
        stat[B_TOGA] = tog_a;
        stat[B_TERR] = time_exceeded;
        stat[B_ERUN] = erase_begun;
        stat[B_TOGB] = sect_hit ? tog_b : 1'b1;
      end
      MD_ESUSP: begin
        stat[B_POLL] = 1'b1;
        stat[B_TOGA] = tog_a;
        stat[B_TOGB] = tog_b;
      end
      default: stat = '0;
    endcase
  end

  always_comb begin
    if (mode == MD_ARRAY) begin
      word = array_data;
    end else begin
      word = {{(DATA_W-STAT_W){1'b0}}, stat};
    end
  end

endmodule

// File: rtl/eo_status_gen.sv
module eo_status_gen
  import eosg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NSECT  = 16,
  parameter int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_kind,
  input  logic              busy,
  input  logic              suspended,
  input  logic              time_exceeded,
  input  logic              erase_begun,
  input  logic              buf_abort,
  input  logic              hw_reset,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [NSECT-1:0]  erase_sel,
  input  logic              rd_req,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ready
);

  rd_mode_e          mode;
  logic              sect_hit;
  logic              tog_a;
  logic              tog_b;
  logic              adv_a;
  logic              adv_b;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] data_q, data_nx;
  logic              valid_q, valid_nx;
  logic              ready_q, ready_nx;

  eosg_mode_dec #(.NSECT(NSECT), .SECT_W(SECT_W)) u_dec (
    .op_kind   (op_kind),
    .busy      (busy),
    .suspended (suspended),
    .erase_sel (erase_sel),
    .rd_sector (rd_sector),
    .mode      (mode),
    .sect_hit  (sect_hit)
  );

  always_comb begin
    adv_a = rd_req && (mode == MD_PROG || mode == MD_ERASE);
    adv_b = rd_req && sect_hit && (mode == MD_ERASE || mode == MD_ESUSP);
  end

  eosg_toggle u_tog_a (.clk(clk), .rst_n(rst_n), .adv(adv_a), .q(tog_a));
  eosg_toggle u_tog_b (.clk(clk), .rst_n(rst_n), .adv(adv_b), .q(tog_b));

  eosg_word_build #(.DATA_W(DATA_W)) u_build (
    .mode          (mode),
    .sect_hit      (sect_hit),
    .tog_a         (tog_a),
    .tog_b         (tog_b),
    .time_exceeded (time_exceeded),
    .erase_begun   (erase_begun),
    .buf_abort     (buf_abort),
    .prog_data     (prog_data),
    .array_data    (array_data),
    .word          (word)
  );

  always_comb begin
    data_nx  = rd_req ? word : data_q;
    valid_nx = rd_req;
    ready_nx = !(busy || hw_reset);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      data_q  <= data_nx;
      valid_q <= valid_nx;
      ready_q <= ready_nx;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
  assign ready    = ready_q;

endmodule

// File: rtl/eosg_chk.sv
module eosg_chk
  import eosg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NSECT  = 16,
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        op_kind,
  input logic              busy,
  input logic              suspended,
  input logic              time_exceeded,
  input logic              hw_reset,
  input logic [DATA_W-1:0] prog_data,
  input logic              rd_req,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              ready
);

  logic run_rd;
  logic tog_rd_q;
  logic have_last;
  logic last6;

  assign run_rd = rd_req && busy && !suspended &&
                  (op_kind == 2'd1 || op_kind == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_rd_q  <= 1'b0;
      have_last <= 1'b0;
      last6     <= 1'b0;
    end else begin
      tog_rd_q <= run_rd;
      if (rd_valid && tog_rd_q) begin
        have_last <= 1'b1;
        last6     <= rd_data[6];
      end
    end
  end

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R2
  no_spur_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R3
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy && !suspended) |=> (rd_data == $past(array_data)));

  // R4
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy && !suspended && op_kind == 2'd1)
      |=> (rd_data[7] == ~$past(prog_data[7])));

  // R5
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && tog_rd_q && have_last) |-> (rd_data[6] != last6));

  // R8
  terr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_rd |=> (rd_data[5] == $past(time_exceeded)));

  // R11
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || hw_reset) |=> !ready);

  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hw_reset) |=> ready);

endmodule

bind eo_status_gen eosg_chk #(
  .DATA_W(DATA_W), .NSECT(NSECT), .SECT_W(SECT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_kind       (op_kind),
  .busy          (busy),
  .suspended     (suspended),
  .time_exceeded (time_exceeded),
  .hw_reset      (hw_reset),
  .prog_data     (prog_data),
  .rd_req        (rd_req),
  .array_data    (array_data),
  .rd_data       (rd_data),
  .rd_valid      (rd_valid),
  .ready         (ready)
);

// File: tb/sim_eo_status_gen.sv
module sim_eo_status_gen;

  localparam int DW = 16;
  localparam int NS = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    op_kind;
  logic          busy, suspended, time_exceeded, erase_begun, buf_abort, hw_reset;
  logic [DW-1:0] prog_data;
  logic [NS-1:0] erase_sel;
  logic          rd_req;
  logic [SW-1:0] rd_sector;
  logic [DW-1:0] array_data;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  bit m6;
  bit m2;

  always #4 clk = ~clk;

  eo_status_gen #(.DATA_W(DW), .NSECT(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .busy(busy),
    .suspended(suspended), .time_exceeded(time_exceeded),
    .erase_begun(erase_begun), .buf_abort(buf_abort), .hw_reset(hw_reset),
    .prog_data(prog_data), .erase_sel(erase_sel), .rd_req(rd_req),
    .rd_sector(rd_sector), .array_data(array_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .ready(ready)
  );

  task automatic check1(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected word from the requirement text; advances the bench's own toggle model.
  function automatic logic [DW-1:0] model(input logic [SW-1:0] sec);
    logic [DW-1:0] w;
    bit hit;
    w   = '0;
    hit = erase_sel[sec];
    if (suspended && op_kind == 2'd2) begin
      if (!hit) return array_data;            // R10
      w[7] = 1'b1; w[6] = m6; w[2] = m2;      // R10
      m2 = ~m2;
      return w;
    end
    if (busy && op_kind == 2'd1) begin        // R4 R9
      w[7] = ~prog_data[7]; w[6] = m6; w[5] = time_exceeded;
      w[2] = 1'b1; w[1] = buf_abort;
      m6 = ~m6;
      return w;
    end
    if (busy && op_kind == 2'd2) begin        // R6 R7
      w[6] = m6; w[5] = time_exceeded; w[3] = erase_begun;
      w[2] = hit ? m2 : 1'b1;
      m6 = ~m6;
      if (hit) m2 = ~m2;
      return w;
    end
    return array_data;                        // R3
  endfunction

  task automatic rd(input logic [SW-1:0] sec, input string tag);
    exp_q.push_back(model(sec));
    tag_q.push_back(tag);
    rd_sector = sec;
    rd_req    = 1'b1;
    @(negedge clk);
    rd_req    = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: every valid pulse pops one expected item.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 actual=unexpected valid expected=no valid");
      end else begin
        check1(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m6 = 1'b0; m2 = 1'b0;
    rst_n = 1'b0; op_kind = 2'd0; busy = 0; suspended = 0; time_exceeded = 0;
    erase_begun = 0; buf_abort = 0; hw_reset = 0; prog_data = '0;
    erase_sel = '0; rd_req = 0; rd_sector = '0; array_data = '0;
    repeat (3) @(negedge clk);
    check1("R1 valid", {15'd0, rd_valid}, 16'd0);
    check1("R1 ready", {15'd0, ready}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R11 idle ready", {15'd0, ready}, 16'd1);

    array_data = 16'h1234; rd(4'd0, "R3 idle read");
    array_data = 16'hBEEF; rd(4'd9, "R3 idle read 2");
    check1("R2 no extra pulse", {15'd0, rd_valid}, 16'd0);

    op_kind = 2'd1; busy = 1; prog_data = 16'h00A5; array_data = 16'hFFFF;
    @(negedge clk);
    check1("R11 busy ready", {15'd0, ready}, 16'd0);
    rd(4'd1, "R4 R5 prog read 1");
    rd(4'd1, "R5 prog read 2");
    rd(4'd1, "R5 prog read 3");
    time_exceeded = 1; buf_abort = 1; prog_data = 16'h0011;
    rd(4'd3, "R8 R9 prog error read");
    time_exceeded = 0; buf_abort = 0;

    busy = 0; array_data = 16'h0011;
    rd(4'd3, "R3 true data after program");
    rd(4'd3, "R5 no advance on array read");
    check1("R11 done ready", {15'd0, ready}, 16'd1);

    op_kind = 2'd2; busy = 1; erase_sel = '0;
    erase_sel[2] = 1; erase_sel[5] = 1; erase_sel[15] = 1;
    rd(4'd2, "R6 R7 erase sel read 1");
    rd(4'd3, "R6 erase unsel read");
    rd(4'd5, "R6 erase sel read 2");
    erase_begun = 1; time_exceeded = 1;
    rd(4'd15, "R7 R8 erase begun top sector");
    time_exceeded = 0;

    busy = 0; suspended = 1; array_data = 16'h5A5A;
    rd(4'd2, "R10 suspend sel 1");
    rd(4'd2, "R10 suspend sel 2");
    rd(4'd4, "R10 suspend unsel");
    busy = 1;
    rd(4'd5, "R10 suspend priority");

    suspended = 0;
    rd(4'd4, "R5 resume continues");
    busy = 0; hw_reset = 1;
    @(negedge clk);
    check1("R11 hw reset ready", {15'd0, ready}, 16'd0);
    hw_reset = 0;
    @(negedge clk);
    check1("R11 after hw reset", {15'd0, ready}, 16'd1);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule